// File: doc/BRIEF.md
# Bus-Matching Width Converter

This block joins a 36-bit long-word path to a port whose width is chosen at reset: 36, 18 or 9 bits. It works in both directions at once. In the splitting direction, every long word taken in is sent out as one, two or four narrow items on successive transfers. In the packing direction, narrow items are gathered until a whole long word has been built, and that word is then offered on the long side. Every port uses a valid/ready handshake. A transfer takes place on a rising clock edge when valid and ready are both high.

Two settings are captured when reset is released: the narrow width and the sub-word order (big or little endian). Both stay fixed until the next reset. In big-endian order the most significant part of a long word travels first. In little-endian order the least significant part travels first. The same rule applies to splitting and to packing. When the narrow port is set to the full 36 bits, the order setting has no effect and both paths pass words straight through. The block is meant to sit between a long-word storage array and a narrower external bus.

Top module: `bus_width_adapter`

## Requirements
- R1: While `rst_n` is low, and in the first clock cycle after it rises, both ready outputs and both valid outputs are low. From the second cycle after release, both ready outputs are high and both valid outputs are low until traffic arrives.
- R2: `cfg_size_i` and `cfg_big_i` are sampled on the first rising clock edge after `rst_n` goes high. Changes to them after that edge have no effect until the next reset. Size codes: 0 gives a 36-bit narrow port (one item per long word), 1 gives 18 bits (two items), 2 or 3 gives 9 bits (four items). `cfg_big_i` = 1 selects big endian.
- R3: When splitting in big-endian mode, the item in long-word bits [36-1-(j)*W ... ] is sent in order, most significant item first. Item j of a long word (j = 0 first) is bits [(n-1-j)*W +: W], where W is the narrow width and n the item count.
- R4: When splitting in little-endian mode, item j is bits [j*W +: W], least significant item first.
- R5: A narrow output item appears in `nar_out_data_o[W-1:0]`. The bits above W are zero.
- R6: When packing in big-endian mode, the j-th narrow item accepted is placed at long-word bits [(n-1-j)*W +: W].
- R7: When packing in little-endian mode, the j-th narrow item accepted is placed at bits [j*W +: W].
- R8: With size code 0, each long word passes unchanged in both directions, whatever the endian setting.
- R9: `wide_out_valid_o` rises only in the cycle after the last item of a long word has been accepted. While it is high, `nar_in_ready_o` is low, and `wide_out_data_o` holds steady until it is accepted.
- R10: While a long word still has more than one item left to send, `wide_in_ready_o` is low. When one item is left, `wide_in_ready_o` equals `nar_out_ready_i`. A narrow output item held without ready stays stable.
- R11: Bits of `nar_in_data_i` above the narrow width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size_i | input | 2 | Narrow width code, sampled at reset release |
| cfg_big_i | input | 1 | 1 = big endian, sampled at reset release |
| wide_in_valid_i | input | 1 | Long word offered for splitting |
| wide_in_ready_o | output | 1 | Splitter can take a long word |
| wide_in_data_i | input | 36 | Long word to split |
| nar_out_valid_o | output | 1 | Narrow item available |
| nar_out_ready_i | input | 1 | Consumer takes the narrow item |
| nar_out_data_o | output | 36 | Narrow item, low-aligned, upper bits zero |
| nar_in_valid_i | input | 1 | Narrow item offered for packing |
| nar_in_ready_o | output | 1 | Packer can take a narrow item |
| nar_in_data_i | input | 36 | Narrow item in the low bits |
| wide_out_valid_o | output | 1 | Packed long word available |
| wide_out_ready_i | input | 1 | Consumer takes the packed long word |
| wide_out_data_o | output | 36 | Packed long word |

## Verification
The hardest case to reach is the splitter's handover. A new long word must be taken on the very edge where the last item of the previous word leaves. This needs the upstream valid and the downstream ready high together, exactly when one item is left. The packer's stall is similar: a finished word must wait while narrow items keep being offered. Random valid and ready draws, tuned separately in each phase, reach both cases many times. A phase with low ready probability keeps the outputs blocked for long stretches. The configuration pins are redrawn every cycle after reset, so any late sampling of them shows up as wrong data.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int unsigned NBYTE = 4;

  typedef enum logic [1:0] {
    SZ_LONG  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_BYTE  = 2'd2,
    SZ_BYTE2 = 2'd3
  } size_e;

  typedef struct packed {
    size_e size;
    logic  big;
  } cfg_t;

  // log2 of byte lanes carried by one narrow item
  function automatic logic [1:0] span_log(size_e s);
    case (s)
      SZ_LONG: return 2'd2;
      SZ_HALF: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/bwc_cfg_latch.sv
module bwc_cfg_latch
  import bwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] size_i,
  input  logic       big_i,
  output logic       act_o,
  output cfg_t       cfg_o
);
  logic act_q;
  logic cfg_en;
  cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_en     = !act_q;
    cfg_d.size = size_e'(size_i);
    cfg_d.big  = big_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cfg_en) cfg_q <= cfg_d;
  end

  assign act_o = act_q;
  assign cfg_o = cfg_q;
endmodule

// File: rtl/bwc_split.sv
module bwc_split
  import bwc_pkg::*;
#(
  parameter  int unsigned BYTE_W = 9,
  localparam int unsigned LW     = BYTE_W * NBYTE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  cfg_t          cfg,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [LW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LW-1:0] out_data
);
  localparam int unsigned IW = $clog2(NBYTE);
  localparam int unsigned CW = IW + 1;

  logic [NBYTE-1:0][BYTE_W-1:0] word_q, out_l;
  logic [CW-1:0] left_q, left_d, nsub, kcnt;
  logic [IW-1:0] idx_q, idx_d, pos, base;
  logic [1:0]    sl;
  logic          take_in, take_out, last, word_en;

  always_comb begin
    sl        = span_log(cfg.size);
    nsub      = CW'(NBYTE >> sl);
    kcnt      = CW'(1 << sl);
    out_valid = (left_q != '0);
    last      = (left_q == CW'(1));
    in_ready  = act && ((left_q == '0) || (last && out_ready));
    take_in   = in_valid && in_ready;
    take_out  = out_valid && out_ready;
    pos       = cfg.big ? IW'(nsub - CW'(1) - CW'(idx_q)) : idx_q;
    base      = pos << sl;
  end

  always_comb begin
    for (int b = 0; b < NBYTE; b++) begin
      if (CW'(b) < kcnt) out_l[b] = word_q[base + IW'(b)];
      else               out_l[b] = '0;
    end
  end
  assign out_data = out_l;

  always_comb begin
    left_d  = left_q;
    idx_d   = idx_q;
    word_en = take_in;
    if (take_in) begin
      left_d = nsub;
      idx_d  = '0;
    end else if (take_out) begin
      left_d = left_q - CW'(1);
      idx_d  = idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      idx_q  <= '0;
    end else begin
      left_q <= left_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (word_en) word_q <= in_data;
  end
endmodule

// File: rtl/bwc_pack.sv
module bwc_pack
  import bwc_pkg::*;
#(
  parameter  int unsigned BYTE_W = 9,
  localparam int unsigned LW     = BYTE_W * NBYTE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  cfg_t          cfg,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [LW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LW-1:0] out_data
);
  localparam int unsigned IW = $clog2(NBYTE);
  localparam int unsigned CW = IW + 1;

  logic [NBYTE-1:0][BYTE_W-1:0] acc_q, acc_d, in_l;
  logic [CW-1:0] got_q, got_d, got_inc, nsub, kcnt;
  logic [IW-1:0] pos, base, off;
  logic [1:0]    sl;
  logic          full_q, full_d, take_in, take_out, wrap, acc_en;

  assign in_l = in_data;

  always_comb begin
    sl       = span_log(cfg.size);
    nsub     = CW'(NBYTE >> sl);
    kcnt     = CW'(1 << sl);
    in_ready = act && !full_q;
    take_in  = in_valid && in_ready;
    take_out = full_q && out_ready;
    got_inc  = got_q + CW'(1);
    wrap     = take_in && (got_inc == nsub);
    pos      = cfg.big ? IW'(nsub - CW'(1) - got_q) : IW'(got_q);
    base     = pos << sl;
  end

  always_comb begin
    acc_en = take_in;
    acc_d  = acc_q;
    off    = '0;
    for (int l = 0; l < NBYTE; l++) begin
      off = IW'(l) - base;
      if (CW'(off) < kcnt) acc_d[l] = in_l[off];
    end
  end

  always_comb begin
    got_d  = got_q;
    full_d = full_q;
    if (take_in) got_d = wrap ? '0 : got_inc;
    if (wrap)          full_d = 1'b1;
    else if (take_out) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q  <= '0;
      full_q <= 1'b0;
    end else begin
      got_q  <= got_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_en) acc_q <= acc_d;
  end

  assign out_valid = full_q;
  assign out_data  = acc_q;
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwc_pkg::*;
#(
  parameter  int unsigned BYTE_W = 9,
  localparam int unsigned LW     = BYTE_W * NBYTE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_size_i,
  input  logic          cfg_big_i,
  input  logic          wide_in_valid_i,
  output logic          wide_in_ready_o,
  input  logic [LW-1:0] wide_in_data_i,
  output logic          nar_out_valid_o,
  input  logic          nar_out_ready_i,
  output logic [LW-1:0] nar_out_data_o,
  input  logic          nar_in_valid_i,
  output logic          nar_in_ready_o,
  input  logic [LW-1:0] nar_in_data_i,
  output logic          wide_out_valid_o,
  input  logic          wide_out_ready_i,
  output logic [LW-1:0] wide_out_data_o
);
  logic act;
  cfg_t cfg_q;

  bwc_cfg_latch u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .size_i (cfg_size_i),
    .big_i  (cfg_big_i),
    .act_o  (act),
    .cfg_o  (cfg_q)
  );

  bwc_split #(.BYTE_W(BYTE_W)) u_split (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .cfg       (cfg_q),
    .in_valid  (wide_in_valid_i),
    .in_ready  (wide_in_ready_o),
    .in_data   (wide_in_data_i),
    .out_valid (nar_out_valid_o),
    .out_ready (nar_out_ready_i),
    .out_data  (nar_out_data_o)
  );

  bwc_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .cfg       (cfg_q),
    .in_valid  (nar_in_valid_i),
    .in_ready  (nar_in_ready_o),
    .in_data   (nar_in_data_i),
    .out_valid (wide_out_valid_o),
    .out_ready (wide_out_ready_i),
    .out_data  (wide_out_data_o)
  );
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
  parameter int unsigned LW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          act,
  input logic [1:0]    cfg_size,
  input logic          cfg_big,
  input logic          wl_valid,
  input logic          wl_ready,
  input logic          nn_valid,
  input logic          nn_ready,
  input logic [LW-1:0] nn_data,
  input logic          nw_ready,
  input logic          lw_valid,
  input logic          lw_ready,
  input logic [LW-1:0] lw_data
);
  // R1: nothing moves before the block is active
  a_r1_quiet_before_active: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (!wl_ready && !nw_ready && !nn_valid && !lw_valid));

  // R2: captured settings never move once active
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act)) |-> ($stable(cfg_size) && $stable(cfg_big)));

  // R10: a stalled narrow item stays put
  a_r10_item_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nn_valid && !nn_ready) |=> (nn_valid && $stable(nn_data)));

  // R10: an accepted long word produces an item next cycle
  a_r10_accept_gives_item: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_valid && wl_ready) |=> nn_valid);

  // R9: packed word held until taken
  a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_valid && !lw_ready) |=> (lw_valid && $stable(lw_data)));

  // R9: no narrow intake while a packed word waits
  a_r9_no_intake_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    lw_valid |-> !nw_ready);
endmodule

bind bus_width_adapter bwc_checker #(.LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .act      (act),
  .cfg_size (cfg_q.size),
  .cfg_big  (cfg_q.big),
  .wl_valid (wide_in_valid_i),
  .wl_ready (wide_in_ready_o),
  .nn_valid (nar_out_valid_o),
  .nn_ready (nar_out_ready_i),
  .nn_data  (nar_out_data_o),
  .nw_ready (nar_in_ready_o),
  .lw_valid (wide_out_valid_o),
  .lw_ready (wide_out_ready_i),
  .lw_data  (wide_out_data_o)
);

// File: tb/tb_bus_width_adapter.sv
module tb_bus_width_adapter;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [1:0]  cfg_size_i;
  logic        cfg_big_i;
  logic        wide_in_valid_i, wide_in_ready_o;
  logic [35:0] wide_in_data_i;
  logic        nar_out_valid_o, nar_out_ready_i;
  logic [35:0] nar_out_data_o;
  logic        nar_in_valid_i, nar_in_ready_o;
  logic [35:0] nar_in_data_i;
  logic        wide_out_valid_o, wide_out_ready_i;
  logic [35:0] wide_out_data_o;

  bus_width_adapter dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  int cur_sz;
  bit cur_big;

  task automatic check(input bit ok, input string tag, input logic [35:0] act_v, input logic [35:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
    end
  endtask

  function automatic int nsub_of(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [35:0] mask_of(input int sz);
    return (sz == 0) ? 36'hF_FFFF_FFFF : (sz == 1) ? 36'h0_0003_FFFF : 36'h0_0000_01FF;
  endfunction

  function automatic int shift_of(input int sz, input bit big, input int j);
    int n = nsub_of(sz);
    int p = big ? (n - 1 - j) : j;
    return p * (36 / n);
  endfunction

  function automatic logic [35:0] rnd36();
    return {4'($urandom), 32'($urandom)};
  endfunction

  function automatic string tag_of(input bit pack);
    if (cur_sz == 0) return "R8";
    if (pack) return cur_big ? "R6,R11" : "R7,R11";
    return cur_big ? "R3,R5" : "R4,R5";
  endfunction

  task automatic do_reset(input int sz, input bit big);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_size_i = 2'(sz);
    cfg_big_i = big;
    wide_in_valid_i = 1'b0;
    nar_in_valid_i = 1'b0;
    nar_out_ready_i = 1'b0;
    wide_out_ready_i = 1'b0;
    repeat (2) @(negedge clk);
    check(!wide_in_ready_o && !nar_in_ready_o && !nar_out_valid_o && !wide_out_valid_o,
          "R1 in reset", {32'd0, wide_in_ready_o, nar_in_ready_o, nar_out_valid_o, wide_out_valid_o}, 36'd0);
    rst_n = 1'b1;
    #1;
    check(!wide_in_ready_o && !nar_in_ready_o, "R1 first cycle after release",
          {34'd0, wide_in_ready_o, nar_in_ready_o}, 36'd0);
    @(negedge clk);
    check(wide_in_ready_o && nar_in_ready_o && !nar_out_valid_o && !wide_out_valid_o,
          "R1 active idle", {32'd0, wide_in_ready_o, nar_in_ready_o, nar_out_valid_o, wide_out_valid_o}, 36'hC);
    cur_sz = sz;
    cur_big = big;
  endtask

  task automatic run(input int nwords, input int vpct, input int rpct);
    logic [35:0] sq[$];
    logic [35:0] pend_w, exp_long, got;
    int n = nsub_of(cur_sz);
    int sent_w = 0, recv_items = 0, rem = 0;
    int acc_cnt = 0, sent_n = 0, recv_w = 0;
    logic [35:0] item;
    bit wt, nt, it, lt;
    pend_w = rnd36();
    exp_long = '0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      if (recv_items >= nwords * n && recv_w >= nwords) break;
      @(negedge clk);
      cfg_size_i = 2'($urandom);
      cfg_big_i = 1'($urandom);
      wide_in_valid_i = (sent_w < nwords) && (($urandom % 100) < vpct);
      wide_in_data_i = pend_w;
      nar_out_ready_i = ($urandom % 100) < rpct;
      nar_in_valid_i = (sent_n < nwords * n) && (($urandom % 100) < vpct);
      nar_in_data_i = rnd36();
      wide_out_ready_i = ($urandom % 100) < rpct;
      #2;
      check(wide_in_ready_o == ((rem == 0) || (rem == 1 && nar_out_ready_i)), "R10 wide_in_ready",
            {35'd0, wide_in_ready_o}, {35'd0, ((rem == 0) || (rem == 1 && nar_out_ready_i))});
      check(nar_out_valid_o == (rem != 0), "R10 nar_out_valid", {35'd0, nar_out_valid_o}, {35'd0, rem != 0});
      check(wide_out_valid_o == (acc_cnt == n), "R9 wide_out_valid", {35'd0, wide_out_valid_o}, {35'd0, acc_cnt == n});
      check(nar_in_ready_o == (acc_cnt != n), "R9 nar_in_ready", {35'd0, nar_in_ready_o}, {35'd0, acc_cnt != n});
      wt = wide_in_valid_i && wide_in_ready_o;
      nt = nar_out_valid_o && nar_out_ready_i;
      it = nar_in_valid_i && nar_in_ready_o;
      lt = wide_out_valid_o && wide_out_ready_i;
      if (nt) begin
        item = (sq.size() > 0) ? sq.pop_front() : 36'hX;
        check(nar_out_data_o === item, tag_of(1'b0), nar_out_data_o, item);
        recv_items++;
        rem--;
      end
      if (wt) begin
        for (int j = 0; j < n; j++)
          sq.push_back((pend_w >> shift_of(cur_sz, cur_big, j)) & mask_of(cur_sz));
        rem += n;
        sent_w++;
        pend_w = rnd36();
      end
      if (lt) begin
        got = wide_out_data_o;
        check(got === exp_long, tag_of(1'b1), got, exp_long);
        recv_w++;
        acc_cnt = 0;
        exp_long = '0;
      end
      if (it) begin
        exp_long |= (nar_in_data_i & mask_of(cur_sz)) << shift_of(cur_sz, cur_big, acc_cnt);
        acc_cnt++;
        sent_n++;
      end
    end
    check(recv_items == nwords * n, "R3 item count", 36'(recv_items), 36'(nwords * n));
    check(recv_w == nwords, "R6 word count", 36'(recv_w), 36'(nwords));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cfg_size_i = '0;
    cfg_big_i = 1'b0;
    wide_in_valid_i = 1'b0;
    wide_in_data_i = '0;
    nar_out_ready_i = 1'b0;
    nar_in_valid_i = 1'b0;
    nar_in_data_i = '0;
    wide_out_ready_i = 1'b0;
    // R2: every size code with both orders; pins are redrawn during traffic
    for (int sz = 0; sz < 4; sz++) begin
      for (int big = 0; big < 2; big++) begin
        do_reset(sz, 1'(big));
        run(24, 70, 60);
        run(8, 100, 100);
        run(8, 90, 15);
      end
    end
    // directed: single-word cases at full width and byte width
    do_reset(0, 1'b1);
    run(1, 100, 100);
    do_reset(2, 1'b1);
    run(1, 100, 100);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 36'd0, 36'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule